// File: doc/BRIEF.md
# Timer interrupt flag controller

This block gathers single-cycle event strobes from eleven timer sources into two 8-bit status flag registers. Each flag has a mask bit in a matching mask register. Whenever any flag is set together with its mask bit, the block drives an interrupt request. The request appears on one of seven prioritized request lines, chosen by a 3-bit level input.

Software reaches the flag pair and the mask pair through a simple bus with two byte-lane enables. One enable alone accesses a single 8-bit register. Both enables together access the pair as one 16-bit word.

Flags are cleared by a handshake. Software first reads the register while the flag is set, then writes a zero to that bit. A flag that fires again in between the read and the write survives that write, so no event is lost.

Top module: `tflag_ctrl`

## Requirements
- R1: After reset, both flag registers, both mask registers and all request lines read as zero.
- R2: An event strobe sets its flag, and the flag reads back set from the next cycle on. Word bits 15:8 hold flag register 1, with bit 8+k driven by ev_i[k] for k = 0..7 (input captures 1 to 3, output compares 1 to 4, then the shared capture-4/compare-5 source). Word bits 7:5 hold flag register 2, driven by ev_i[8], ev_i[9] and ev_i[10] (timer overflow, accumulator overflow, accumulator edge).
- R3: Flag register 2 bits 4:0 always read zero. Mask register 2 bits 4:0 are plain read/write storage.
- R4: A flag read (bus_rd_i=1, bus_sel_flag_i=1) taken while a flag is set arms that flag. A later flag write with a 0 in that bit position clears the flag, and it reads zero from the next cycle.
- R5: Writing a 1 to a flag bit leaves it unchanged. Writing a 0 to a flag that is not armed also leaves it unchanged.
- R6: An event on an armed flag, arriving after the read and before the write, disarms that flag, so the following zero-write leaves it set.
- R7: An event strobe in the same cycle as a clearing write wins, and the flag stays set.
- R8: Any flag write to a lane consumes every arm bit of that lane. A second zero-write that has no new read in front of it clears nothing.
- R9: Accesses affect only the enabled lanes. bus_be_i[1] selects register 1 (word bits 15:8) and bus_be_i[0] selects register 2 (bits 7:0). Disabled lanes read zero and are neither written nor armed. A mask write (bus_sel_flag_i=0) stores the enabled bytes.
- R10: When any flag is set together with its mask bit and lvl_i = n (1 to 7), exactly irq_o[n-1] is high, in the same cycle. When lvl_i = 0, or when no enabled flag is pending, irq_o is zero. At most one line is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 11 | Single-cycle event strobes, one per source |
| bus_sel_flag_i | input | 1 | 1 selects the flag pair, 0 selects the mask pair |
| bus_be_i | input | 2 | Lane enables: [1] register 1, [0] register 2 |
| bus_rd_i | input | 1 | Read strobe; arms set flags on a flag read |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected pair, disabled lanes zero |
| lvl_i | input | 3 | Priority level selecting the request line |
| irq_o | output | 7 | Request lines; bit n-1 is line n |

## Verification
The bench aims at the gaps in the clearing handshake:
- A design that clears on any zero-write would lose events. So would one that ignores an event arriving between the read and the write, or one that lets a same-cycle clearing write beat an event.
- A design that kept arm bits after a write would clear a flag on a second, unread zero-write.

Lane handling is driven with single-byte and word accesses, to catch a leak into a disabled byte. The level decoder is exercised across all eight levels, to catch lines that are off by one or driven together.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_SRC   = 11;
    localparam int LVL_W     = 3;
    localparam int NUM_LINES = (1 << LVL_W) - 1;
    localparam logic [REG_W-1:0] IMPL_R1 = 8'hFF;
    localparam logic [REG_W-1:0] IMPL_R2 = 8'hE0;

    typedef struct packed {
        logic [REG_W-1:0] flag;
        logic [REG_W-1:0] arm;
    } bank_st_t;

    typedef struct packed {
        logic [REG_W-1:0] m1;
        logic [REG_W-1:0] m2;
    } mask_st_t;
endpackage

// File: rtl/tflag_bank.sv
module tflag_bank
    import tflag_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ev_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] flag_o
);
    bank_st_t st_d, st_q;
    logic [REG_W-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = wr_i ? (st_q.arm & ~wdata_i) : '0;
        st_d.arm = wr_i ? '0 : st_q.arm;
        if (rd_i) st_d.arm = st_d.arm | (st_q.flag & ~clr);
        st_d.flag = ((st_q.flag & ~clr) | ev_i) & IMPL;
        st_d.arm  = st_d.arm & ~ev_i & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_i & IMPL)) |=> ((st_q.flag & $past(ev_i & IMPL)) == $past(ev_i & IMPL)));
    // R5
    no_clear_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.flag) & ~st_q.flag & ~$past(st_q.arm)) == '0));
    // R6
    arm_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arm & ~st_q.flag) == '0);
endmodule

// File: rtl/tflag_irq.sv
module tflag_irq
    import tflag_pkg::*;
(
    input  logic                 pend_i,
    input  logic [LVL_W-1:0]     lvl_i,
    output logic [NUM_LINES-1:0] irq_o
);
    for (genvar n = 1; n <= NUM_LINES; n++) begin : g_line
        assign irq_o[n-1] = pend_i && (lvl_i == LVL_W'(n));
    end

    // R10
    one_line_chk: assert final ($onehot0(irq_o));
endmodule

// File: rtl/tflag_ctrl.sv
module tflag_ctrl
    import tflag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   ev_i,
    input  logic                 bus_sel_flag_i,
    input  logic [1:0]           bus_be_i,
    input  logic                 bus_rd_i,
    input  logic                 bus_wr_i,
    input  logic [2*REG_W-1:0]   bus_wdata_i,
    output logic [2*REG_W-1:0]   bus_rdata_o,
    input  logic [LVL_W-1:0]     lvl_i,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [REG_W-1:0] ev_bank [2];
    logic [REG_W-1:0] flag_bank [2];
    mask_st_t mk_d, mk_q;
    logic [2*REG_W-1:0] flags_w, masks_w, lane_w;
    logic pend;

    always_comb begin
        ev_bank[0] = ev_i[REG_W-1:0];
        ev_bank[1] = {ev_i[8], ev_i[9], ev_i[10], 5'b0};
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam logic [REG_W-1:0] IMPL_G = (g == 0) ? IMPL_R1 : IMPL_R2;
        tflag_bank #(.IMPL(IMPL_G)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev_bank[g]),
            .rd_i    (bus_rd_i & bus_sel_flag_i & bus_be_i[1-g]),
            .wr_i    (bus_wr_i & bus_sel_flag_i & bus_be_i[1-g]),
            .wdata_i (bus_wdata_i[(1-g)*REG_W +: REG_W]),
            .flag_o  (flag_bank[g])
        );
    end

    always_comb begin
        mk_d = mk_q;
        if (bus_wr_i && !bus_sel_flag_i) begin
            if (bus_be_i[1]) mk_d.m1 = bus_wdata_i[2*REG_W-1:REG_W];
            if (bus_be_i[0]) mk_d.m2 = bus_wdata_i[REG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign flags_w = {flag_bank[0], flag_bank[1]};
    assign masks_w = {mk_q.m1, mk_q.m2};
    assign lane_w  = {{REG_W{bus_be_i[1]}}, {REG_W{bus_be_i[0]}}};
    assign bus_rdata_o = (bus_sel_flag_i ? flags_w : masks_w) & lane_w;
    assign pend = |(flags_w & masks_w);

    tflag_irq u_irq (
        .pend_i (pend),
        .lvl_i  (lvl_i),
        .irq_o  (irq_o)
    );

    // R10
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> (|(flags_w & masks_w)) && (lvl_i != '0));
    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && !bus_sel_flag_i) |=> $stable(masks_w));
endmodule

// File: tb/sim_tflag_ctrl.sv
module sim_tflag_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [10:0] ev = '0;
    logic        sel = 0;
    logic [1:0]  be = '0;
    logic        rd = 0, wr = 0;
    logic [15:0] wdata = '0, rdata;
    logic [2:0]  lvl = '0;
    logic [6:0]  irq;

    int checks = 0, errors = 0;
    logic [15:0] ef = '0, ea = '0, em = '0;
    localparam logic [15:0] IMPL = 16'hFFE0;

    tflag_ctrl u0 (.clk(clk), .rst_n(rst_n), .ev_i(ev), .bus_sel_flag_i(sel),
        .bus_be_i(be), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .lvl_i(lvl), .irq_o(irq));

    always #5 clk = ~clk;

    function automatic logic [15:0] lane_of(logic [1:0] b);
        return {{8{b[1]}}, {8{b[0]}}};
    endfunction

    function automatic logic [6:0] exp_irq(logic [15:0] f, logic [15:0] m, logic [2:0] l);
        logic [6:0] r = '0;
        if ((|(f & m)) && l != 0) r[l-1] = 1'b1;
        return r;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [15:0] ln, evv, wrf, rdf, clr, a;
        ln  = lane_of(be);
        evv = {ev[7:0], ev[8], ev[9], ev[10], 5'b0};
        wrf = (wr && sel) ? ln : '0;
        rdf = (rd && sel) ? ln : '0;
        clr = wrf & ea & ~wdata;
        a   = (ea & ~wrf) | (rdf & ef & ~clr);
        ef  = ((ef & ~clr) | evv) & IMPL;
        ea  = a & ~evv & IMPL;
        if (wr && !sel) em = (em & ~ln) | (wdata & ln);
    endtask

    // drive one cycle at the negedge, check combinational outputs, then advance
    task automatic cyc(string tag, logic [10:0] e, logic s, logic [1:0] b,
                       logic r, logic w, logic [15:0] d);
        @(negedge clk);
        ev = e; sel = s; be = b; rd = r; wr = w; wdata = d;
        #1;
        chk(tag, rdata, (s ? ef : em) & lane_of(b));
        chk({tag, " irq R10"}, {9'b0, irq}, {9'b0, exp_irq(ef, em, lvl)});
        @(posedge clk);
        model_step();
    endtask

    task automatic peek_flags(string tag, logic [15:0] exp);
        @(negedge clk);
        ev = '0; sel = 1; be = 2'b11; rd = 0; wr = 0;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        #23 rst_n = 1;
        // R1 reset state
        peek_flags("R1 flags", 16'h0);
        @(negedge clk); sel = 0; be = 2'b11; #1;
        chk("R1 masks", rdata, 16'h0);
        chk("R1 irq", {9'b0, irq}, 16'h0);

        // R2 event placement
        cyc("R2 ev", 11'b101_0000_0001, 0, 2'b00, 0, 0, 0);
        peek_flags("R2 placement", 16'h01A0);
        // R3 low bits of reg2 flags never set, mask storage works
        cyc("R3 wr", 0, 0, 2'b01, 0, 1, 16'h001F);
        cyc("R3 rd", 0, 0, 2'b01, 1, 0, 0);
        @(negedge clk); sel = 0; be = 2'b01; rd = 0; wr = 0; #1;
        chk("R3 mask low", rdata, 16'h001F);
        // R5 zero-write without read leaves flags
        cyc("R5 wr0", 0, 1, 2'b11, 0, 1, 16'h0000);
        peek_flags("R5 unarmed", 16'h01A0);
        // R4 read then write zero clears IC1 only
        cyc("R4 rd", 0, 1, 2'b11, 1, 0, 0);
        cyc("R4 wr", 0, 1, 2'b11, 0, 1, 16'hFEFF);
        peek_flags("R4 cleared", 16'h00A0);
        // R8 arm consumed: read, write ones, write zeros -> no clear
        cyc("R8 rd", 0, 1, 2'b11, 1, 0, 0);
        cyc("R8 wr1", 0, 1, 2'b11, 0, 1, 16'hFFFF);
        cyc("R8 wr0", 0, 1, 2'b11, 0, 1, 16'h0000);
        peek_flags("R8 kept", 16'h00A0);
        // R6 event between read and write
        cyc("R6 rd", 0, 1, 2'b01, 1, 0, 0);
        cyc("R6 ev", 11'b100_0000_0000, 0, 2'b00, 0, 0, 0);
        cyc("R6 wr", 0, 1, 2'b01, 0, 1, 16'h0000);
        peek_flags("R6 survive", 16'h0020);
        // R7 event same cycle as clearing write
        cyc("R7 rd", 0, 1, 2'b01, 1, 0, 0);
        cyc("R7 wr", 11'b100_0000_0000, 1, 2'b01, 0, 1, 16'h0000);
        peek_flags("R7 wins", 16'h0020);
        // R9 lane isolation: set OC4, read lane 0 only, write lane1 zero -> kept
        cyc("R9 ev", 11'b000_0100_0000, 0, 2'b00, 0, 0, 0);
        cyc("R9 rd lo", 0, 1, 2'b01, 1, 0, 0);
        cyc("R9 wr hi", 0, 1, 2'b10, 0, 1, 16'h0000);
        peek_flags("R9 lane", 16'h4020);
        cyc("R9 mask hi", 0, 0, 2'b10, 0, 1, 16'h40FF);
        @(negedge clk); sel = 0; be = 2'b11; rd = 0; wr = 0; #1;
        chk("R9 mask word", rdata, 16'h401F);
        // R10 all levels with OC4 pending and masked
        for (int l = 0; l < 8; l++) begin
            @(negedge clk); lvl = 3'(l); ev = '0; rd = 0; wr = 0; #1;
            chk("R10 level", {9'b0, irq}, {9'b0, (l == 0) ? 7'b0 : 7'(1 << (l-1))});
        end

        // random
        for (int i = 0; i < 3000; i++) begin
            logic [10:0] e;
            e = (($urandom % 4) == 0) ? 11'(1 << ($urandom % 11)) : '0;
            lvl = 3'($urandom);
            cyc("R2 R4 random", e, 1'($urandom), 2'($urandom), 1'($urandom),
                (($urandom % 3) == 0), 16'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule